// File: doc/BRIEF.md
# External Memory Bus Chip-Select and Address Controller

This block sits between a small microcontroller core and an external 8-bit memory bus. The core hands it one request at a time: a 24-bit address, a flag that says whether the access is to program space or to data space, a write flag and a write byte. The block then runs one external bus cycle. It drives the address lines and asserts one active-low device enable. It pulses the strobe that matches the access and returns the read byte to the core with a one-cycle response pulse.

A 3-bit configuration value sets how many of the six upper address lines (A16 and up) are driven. The device-enable index comes from the address bits just above the highest driven line, so this value also sets how large a window each enable covers. Program accesses select one of eight chip enables. Data accesses select one of four peripheral enables. Each enable has its own mask bit. A mode input picks the bus style. In multiplexed mode the low address byte and the data share one port, and an address-latch pulse marks the address. In demultiplexed mode the low address byte has a port of its own.

Top module: `xbus_ctrl`

## Requirements
- R1: Out of reset all of ceN, pceN, psenN, rdN and wrN are high, ale and adOe are low, and reqReady is high.
- R2: addrHi always equals address bits 15..8. With n = upperCfg (values above 6 act as 6), addrUp bit i equals address bit 16+i for i < n and is 0 otherwise.
- R3: A program access (reqIsData = 0) drives ceN[k] low during both the address phase and the data phase, where k = address bits [16+n+2 : 16+n]. It drives psenN low during the data phase only and leaves rdN and wrN high. The write flag is ignored, so the access is always a read.
- R4: A data access drives pceN[k] low during both phases, where k = address bits [16+n+1 : 16+n]. During the data phase it drives rdN low for a read or wrN low for a write, and psenN stays high.
- R5: An enable whose bit is 0 in ceMask or pceMask never goes low, even when the address selects it.
- R6: If any address bit above the index field is 1 (bits at positions of 24 or more count as 0), no enable goes low.
- R7: In multiplexed mode (muxMode = 0), the address phase has ale high, adOe high and adOut equal to address bits 7..0. The data phase has ale low, and addrLo is 0 throughout.
- R8: In demultiplexed mode (muxMode = 1), addrLo equals address bits 7..0, ale stays low, and adOe is low during the address phase.
- R9: On reads, adOe is low during the data phase. rspData returns adIn as sampled in the last data-phase cycle, and rspValid is high for exactly one cycle as the bus returns to idle.
- R10: On data writes, adOut equals the write byte and adOe is high during the data phase.
- R11: At most one enable (across ceN and pceN) is low at any time, and at most one of psenN, rdN and wrN is low. No strobe is low while ale is high.
- R12: A request is taken when reqValid and reqReady are both high. The address phase lasts one cycle and the data phase lasts DATA_CYCLES cycles (2 by default). Enables and strobes are released on the cycle that rspValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Block idle, able to accept a request |
| reqIsData | input | 1 | 1 = data-space access, 0 = program-space access |
| reqWrite | input | 1 | 1 = write (data space only) |
| reqAddr | input | 24 | Internal byte address |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | One-cycle pulse when the access completes |
| rspData | output | 8 | Read byte |
| upperCfg | input | 3 | Number of upper address lines driven |
| ceMask | input | 8 | Per chip-enable enable bits |
| pceMask | input | 4 | Per peripheral-enable enable bits |
| muxMode | input | 1 | 0 = multiplexed, 1 = demultiplexed |
| addrUp | output | 6 | Upper address lines A21..A16 |
| addrHi | output | 8 | Address lines A15..A8 |
| addrLo | output | 8 | Low address byte (demultiplexed mode) |
| adOut | output | 8 | Shared address/data port, output value |
| adOe | output | 1 | Output enable for the shared port |
| adIn | input | 8 | Shared port, input value |
| ale | output | 1 | Address latch enable (multiplexed mode) |
| psenN | output | 1 | Program store enable, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| ceN | output | 8 | Program chip enables, active low |
| pceN | output | 4 | Peripheral enables, active low |

## Verification
The bench moves the index field through several upperCfg values, including 0, 6 and the out-of-range 7. A decoder that takes the index from a fixed position, or that does not clamp, would assert the wrong enable or drive extra upper lines. It also sets a bit just above the index field and clears the mask bit of the selected device. A design that ignores either case would assert an enable that must stay quiet. Both bus modes are run with reads and writes. This exposes an ale that is active in demultiplexed mode, a shared port that is driven during a read, or a low byte on the wrong port. A program request that carries the write flag checks that a write strobe never appears on program space.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } busPhase_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic accept;     // latch the request this cycle
    logic addrPhase;  // address phase active
    logic dataPhase;  // data phase active
    logic capture;    // last data cycle: sample read data
  } busStrobe_t;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DATA_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  output busStrobe_t stb
);
  localparam int CNT_W = (DATA_CYCLES > 1) ? $clog2(DATA_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_CYCLES - 1);

  busPhase_t phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      case (phase)
        PH_IDLE: if (reqValid) phase <= PH_ADDR;
        PH_ADDR: begin
          phase <= PH_DATA;
          cnt   <= '0;
        end
        PH_DATA: begin
          if (cnt == LAST) begin
            phase    <= PH_IDLE;
            rspValid <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady      = (phase == PH_IDLE);
    stb.accept    = (phase == PH_IDLE) && reqValid;
    stb.addrPhase = (phase == PH_ADDR);
    stb.dataPhase = (phase == PH_DATA);
    stb.capture   = (phase == PH_DATA) && (cnt == LAST);
  end
endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int UP_LINES = 6,
  parameter int NUM_CE   = 8,
  parameter int NUM_PCE  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         stb,
  input  logic               reqIsData,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [7:0]         reqWdata,
  input  logic [2:0]         upperCfg,
  input  logic [NUM_CE-1:0]  ceMask,
  input  logic [NUM_PCE-1:0] pceMask,
  input  logic               muxMode,
  input  logic [7:0]         adIn,
  output logic [7:0]         rspData,
  output logic [UP_LINES-1:0] addrUp,
  output logic [7:0]         addrHi,
  output logic [7:0]         addrLo,
  output logic [7:0]         adOut,
  output logic               adOe,
  output logic               ale,
  output logic               psenN,
  output logic               rdN,
  output logic               wrN,
  output logic [NUM_CE-1:0]  ceN,
  output logic [NUM_PCE-1:0] pceN
);
  localparam int CE_IW  = $clog2(NUM_CE);
  localparam int PCE_IW = $clog2(NUM_PCE);
  localparam int EXT_W  = ADDR_W + CE_IW;
  localparam int POS_W  = $clog2(EXT_W + 1);
  localparam int BASE   = 16;

  logic              curData, curWrite;
  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        curWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curData  <= 1'b0;
      curWrite <= 1'b0;
      curAddr  <= '0;
      curWdata <= '0;
      rspData  <= '0;
    end else begin
      if (stb.accept) begin
        curData  <= reqIsData;
        curWrite <= reqWrite & reqIsData;  // program space is read-only
        curAddr  <= reqAddr;
        curWdata <= reqWdata;
      end
      if (stb.capture && !curWrite) rspData <= adIn;
    end
  end

  // Upper line count, clamped to the number of lines present
  logic [2:0] nUp;
  assign nUp = (upperCfg > 3'(UP_LINES)) ? 3'(UP_LINES) : upperCfg;

  genvar gi;
  generate
    for (gi = 0; gi < UP_LINES; gi++) begin : g_up
      assign addrUp[gi] = (3'(gi) < nUp) ? curAddr[BASE+gi] : 1'b0;
    end
  endgenerate

  // Index decode on a zero-extended address
  logic [EXT_W-1:0]  extAddr;
  logic [POS_W-1:0]  idxPos;
  logic [CE_IW-1:0]  ceIdx;
  logic [PCE_IW-1:0] pceIdx;
  logic              ceOver, pceOver, active;

  always_comb begin
    extAddr = {{CE_IW{1'b0}}, curAddr};
    idxPos  = POS_W'(BASE) + POS_W'(nUp);
    ceIdx   = extAddr[idxPos +: CE_IW];
    pceIdx  = extAddr[idxPos +: PCE_IW];
    ceOver  = (extAddr >> (idxPos + POS_W'(CE_IW))) != '0;
    pceOver = (extAddr >> (idxPos + POS_W'(PCE_IW))) != '0;
    active  = stb.addrPhase | stb.dataPhase;

    ceN  = '1;
    pceN = '1;
    if (active && !curData && !ceOver)
      ceN = ~(ceMask & (NUM_CE'(1) << ceIdx));
    if (active && curData && !pceOver)
      pceN = ~(pceMask & (NUM_PCE'(1) << pceIdx));
  end

  // Address and data ports
  always_comb begin
    addrHi = curAddr[15:8];
    addrLo = muxMode ? curAddr[7:0] : 8'h00;
    ale    = stb.addrPhase && !muxMode;
    adOut  = 8'h00;
    adOe   = 1'b0;
    if (stb.addrPhase && !muxMode) begin
      adOut = curAddr[7:0];
      adOe  = 1'b1;
    end else if (stb.dataPhase && curWrite) begin
      adOut = curWdata;
      adOe  = 1'b1;
    end
    psenN = ~(stb.dataPhase && !curData);
    rdN   = ~(stb.dataPhase && curData && !curWrite);
    wrN   = ~(stb.dataPhase && curData && curWrite);
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int UP_LINES    = 6,
  parameter int NUM_CE      = 8,
  parameter int NUM_PCE     = 4,
  parameter int DATA_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqIsData,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [7:0]          reqWdata,
  output logic                rspValid,
  output logic [7:0]          rspData,
  input  logic [2:0]          upperCfg,
  input  logic [NUM_CE-1:0]   ceMask,
  input  logic [NUM_PCE-1:0]  pceMask,
  input  logic                muxMode,
  output logic [UP_LINES-1:0] addrUp,
  output logic [7:0]          addrHi,
  output logic [7:0]          addrLo,
  output logic [7:0]          adOut,
  output logic                adOe,
  input  logic [7:0]          adIn,
  output logic                ale,
  output logic                psenN,
  output logic                rdN,
  output logic                wrN,
  output logic [NUM_CE-1:0]   ceN,
  output logic [NUM_PCE-1:0]  pceN
);
  busStrobe_t stb;

  xbus_seq #(.DATA_CYCLES(DATA_CYCLES)) u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .rspValid(rspValid), .stb(stb)
  );

  xbus_datapath #(
    .ADDR_W(ADDR_W), .UP_LINES(UP_LINES), .NUM_CE(NUM_CE), .NUM_PCE(NUM_PCE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqIsData(reqIsData), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .upperCfg(upperCfg), .ceMask(ceMask),
    .pceMask(pceMask), .muxMode(muxMode), .adIn(adIn), .rspData(rspData),
    .addrUp(addrUp), .addrHi(addrHi), .addrLo(addrLo), .adOut(adOut),
    .adOe(adOe), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .ceN(ceN), .pceN(pceN)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int UP_LINES = 6,
  parameter int NUM_CE   = 8,
  parameter int NUM_PCE  = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqReady,
  input logic                rspValid,
  input logic [2:0]          upperCfg,
  input logic [NUM_CE-1:0]   ceMask,
  input logic [NUM_PCE-1:0]  pceMask,
  input logic                muxMode,
  input logic [UP_LINES-1:0] addrUp,
  input logic                adOe,
  input logic                ale,
  input logic                psenN,
  input logic                rdN,
  input logic                wrN,
  input logic [NUM_CE-1:0]   ceN,
  input logic [NUM_PCE-1:0]  pceN
);
  p_one_enable_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(~ceN) + $countones(~pceN)) <= 1);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~psenN, ~rdN, ~wrN}));

  p_ale_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (psenN && rdN && wrN));

  p_mask_ce_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((~ceN & ~ceMask) == '0) && ((~pceN & ~pceMask) == '0));

  p_read_float_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !psenN) |-> !adOe);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_rsp_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (reqReady && (&ceN) && (&pceN) && psenN && rdN && wrN));

  p_demux_no_ale_r8: assert property (@(posedge clk) disable iff (!rstN)
    muxMode |-> !ale);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (upperCfg == 3'd0) |-> (addrUp == '0));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(
  .UP_LINES(UP_LINES), .NUM_CE(NUM_CE), .NUM_PCE(NUM_PCE)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .upperCfg(upperCfg), .ceMask(ceMask), .pceMask(pceMask), .muxMode(muxMode),
  .addrUp(addrUp), .adOe(adOe), .ale(ale), .psenN(psenN), .rdN(rdN),
  .wrN(wrN), .ceN(ceN), .pceN(pceN)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIsData = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0, adIn = '0;
  logic [2:0]  upperCfg = '0;
  logic [7:0]  ceMask = 8'hFF;
  logic [3:0]  pceMask = 4'hF;
  logic        muxMode = 1'b0;
  logic        reqReady, rspValid, adOe, ale, psenN, rdN, wrN;
  logic [7:0]  rspData, addrHi, addrLo, adOut, ceN;
  logic [5:0]  addrUp;
  logic [3:0]  pceN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsData(reqIsData), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .upperCfg(upperCfg), .ceMask(ceMask), .pceMask(pceMask),
    .muxMode(muxMode), .addrUp(addrUp), .addrHi(addrHi), .addrLo(addrLo),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .ale(ale), .psenN(psenN),
    .rdN(rdN), .wrN(wrN), .ceN(ceN), .pceN(pceN)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] expUp(input logic [23:0] a, input logic [2:0] c);
    logic [5:0] r = '0;
    int n = (c > 3'd6) ? 6 : int'(c);
    for (int i = 0; i < 6; i++) if (i < n) r[i] = a[16+i];
    return r;
  endfunction

  // One bus access; expCe/expPce are active-high expected enables
  task automatic runAccess(input bit isData, input bit wr, input logic [23:0] a,
                           input logic [7:0] wd, input logic [7:0] rdIn,
                           input logic [7:0] expCe, input logic [3:0] expPce,
                           input string tag);
    bit realWr = isData && wr;
    @(negedge clk);
    reqValid = 1; reqIsData = isData; reqWrite = wr; reqAddr = a;
    reqWdata = wd; adIn = rdIn;
    @(negedge clk);  // address phase
    reqValid = 0;
    chk(!reqReady, {tag, " R12 busy"}, reqReady, 0);
    chk(ale == !muxMode, {tag, " R7/R8 ale addr"}, ale, !muxMode);
    chk(adOe == !muxMode, {tag, " R7/R8 adOe addr"}, adOe, !muxMode);
    if (!muxMode) chk(adOut == a[7:0], {tag, " R7 adOut addr"}, adOut, a[7:0]);
    chk(addrLo == (muxMode ? a[7:0] : 8'h00), {tag, " R7/R8 addrLo"}, addrLo,
        muxMode ? a[7:0] : 8'h00);
    chk(addrHi == a[15:8], {tag, " R2 addrHi"}, addrHi, a[15:8]);
    chk(addrUp == expUp(a, upperCfg), {tag, " R2 addrUp"}, addrUp, expUp(a, upperCfg));
    chk(ceN == ~expCe, {tag, " R3/R5/R6 ceN addr"}, ceN, ~expCe);
    chk(pceN == ~expPce, {tag, " R4/R5/R6 pceN addr"}, pceN, ~expPce);
    chk(psenN && rdN && wrN, {tag, " R11 no strobe in addr"}, {psenN, rdN, wrN}, 3'b111);
    @(negedge clk);  // data phase, first cycle
    chk(!ale, {tag, " R7 ale data"}, ale, 0);
    chk(psenN == isData, {tag, " R3 psenN"}, psenN, isData);
    chk(rdN == !(isData && !wr), {tag, " R4 rdN"}, rdN, !(isData && !wr));
    chk(wrN == !realWr, {tag, " R4 wrN"}, wrN, !realWr);
    chk(adOe == realWr, {tag, " R9/R10 adOe data"}, adOe, realWr);
    if (realWr) chk(adOut == wd, {tag, " R10 adOut"}, adOut, wd);
    chk(ceN == ~expCe, {tag, " R3 ceN data"}, ceN, ~expCe);
    chk(pceN == ~expPce, {tag, " R4 pceN data"}, pceN, ~expPce);
    @(negedge clk);  // data phase, last cycle
    chk(rspValid == 0, {tag, " R12 no early rsp"}, rspValid, 0);
    @(negedge clk);  // completion
    chk(rspValid, {tag, " R9 rspValid"}, rspValid, 1);
    chk(reqReady && (&ceN) && (&pceN) && psenN && rdN && wrN,
        {tag, " R12 release"}, {ceN, pceN, psenN, rdN, wrN}, 15'h7FFF);
    if (!realWr) chk(rspData == rdIn, {tag, " R9 rspData"}, rspData, rdIn);
    @(negedge clk);
    chk(!rspValid, {tag, " R9 single pulse"}, rspValid, 0);
  endtask

  task automatic t_reset();
    chk(&ceN && &pceN && psenN && rdN && wrN, "R1 enables high",
        {ceN, pceN, psenN, rdN, wrN}, 15'h7FFF);
    chk(!ale && !adOe && reqReady, "R1 ale/adOe/ready", {ale, adOe, reqReady}, 3'b001);
  endtask

  task automatic t_prog_mux();
    muxMode = 0; upperCfg = 3'd2; ceMask = 8'hFF; pceMask = 4'hF;
    runAccess(0, 0, 24'h0ABCDE, 8'h00, 8'hC3, 8'h04, 4'h0, "prog mux cfg2");
  endtask

  task automatic t_data_wr_demux();
    muxMode = 1; upperCfg = 3'd0;
    runAccess(1, 1, 24'h031234, 8'hA7, 8'h00, 8'h00, 4'h8, "data wr demux cfg0");
  endtask

  task automatic t_data_rd_mux();
    muxMode = 0; upperCfg = 3'd4;
    runAccess(1, 0, 24'h100055, 8'h00, 8'h5A, 8'h00, 4'h2, "data rd mux cfg4");
  endtask

  task automatic t_masked();
    muxMode = 0; upperCfg = 3'd2; ceMask = 8'hFB; pceMask = 4'h7;
    runAccess(0, 0, 24'h0ABCDE, 8'h00, 8'h11, 8'h00, 4'h0, "R5 ce masked");
    upperCfg = 3'd0;
    runAccess(1, 0, 24'h030000, 8'h00, 8'h22, 8'h00, 4'h0, "R5 pce masked");
    ceMask = 8'hFF; pceMask = 4'hF;
  endtask

  task automatic t_out_of_range();
    muxMode = 1; upperCfg = 3'd0;
    runAccess(0, 0, 24'h080000, 8'h00, 8'h33, 8'h00, 4'h0, "R6 prog above");
    upperCfg = 3'd2;
    runAccess(1, 1, 24'h100000, 8'h44, 8'h00, 8'h00, 4'h0, "R6 data above");
  endtask

  task automatic t_cfg_top();
    muxMode = 0; upperCfg = 3'd6;
    runAccess(0, 1, 24'hE50000, 8'h99, 8'h66, 8'h08, 4'h0, "R2/R3 cfg6 prog wr-flag");
    upperCfg = 3'd7;
    runAccess(0, 0, 24'hE50000, 8'h00, 8'h77, 8'h08, 4'h0, "R2 cfg7 clamps");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_prog_mux();
    t_data_wr_demux();
    t_data_rd_mux();
    t_masked();
    t_out_of_range();
    t_cfg_top();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule